// File: doc/BRIEF.md
# Framebuffer Window Line Fetcher

This block produces the read-request stream for one overlay window of a display controller. The window is a rectangle inside a larger framebuffer. The block works out where that rectangle lives in memory from the window settings: base address, origin coordinates, framebuffer pitch, framebuffer width, window width, window height and pixel depth. It then walks the rectangle line by line and issues burst read requests. Each request gives a word-aligned start address and a length in 32-bit words.

A one-cycle `frame_start` pulse latches the geometry and restarts the walk. Requests leave on a valid/ready pair. A request is transferred on a clock edge where `req_valid` and `req_ready` are both high. While `req_ready` is low, the pending request stays on the bus unchanged, and no later request is formed until it is accepted. After the last request of the rectangle is accepted, `done` rises and stays high until the next frame start.

The configuration inputs must be stable in the cycle where `frame_start` is high. The window must fit inside the framebuffer (window width ≤ framebuffer width). Line byte counts and origin offsets are expected to be multiples of four bytes.

Top module: `win_line_fetch`

## Requirements
- R1: After reset, `req_valid` and `done` are both low, and they stay low until a frame start.
- R2: One cycle after a `frame_start` pulse, the first request address is base + (org_x × bits)/8 + org_y × pitch, where bits is the effective bits per pixel.
- R3: The burst length is set by the depth value. A depth of 1 gives 4-word bursts. Depths of 2, 4 and 8 give 8-word bursts. Depths of 16, 24 and 32 give 16-word bursts.
- R4: Any other depth value is handled as unpacked 24-bit colour. It is stored as 32 bits per pixel and uses 16-word bursts.
- R5: A line covers window_width × bits / 8 bytes. Within a line, each request starts 4 × (previous length) bytes after the previous one. When fewer words than one burst remain, the last request of the line carries only the remaining words.
- R6: The first request of each following line starts (fb_width − win_width) × bits / 8 bytes past the end of the previous line.
- R7: The walk ends at start + (fb_width × bits / 8) × win_height. No request reaches past this end address. `done` goes high in the cycle after the last request is accepted and stays high with `req_valid` low.
- R8: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_addr` and `req_words` hold their values.
- R9: A `frame_start` pulse during a walk, or after `done`, clears `done` and restarts the walk from the start address.
- R10: If the window height is zero, or the line is shorter than one word, a frame start issues no request and raises `done` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | One-cycle pulse: latch geometry, restart walk |
| base_addr | input | AW | Framebuffer base byte address |
| org_x | input | DW | Window origin column in pixels |
| org_y | input | DW | Window origin row |
| pitch | input | PW | Framebuffer bytes per row |
| fb_width | input | DW | Framebuffer width in pixels |
| win_width | input | DW | Window width in pixels |
| win_height | input | DW | Window height in rows |
| depth | input | 6 | Bits per pixel code |
| req_valid | output | 1 | Request pending |
| req_ready | input | 1 | Memory side accepts request |
| req_addr | output | AW | Request byte address (word aligned) |
| req_words | output | 5 | Request length in 32-bit words |
| done | output | 1 | Whole window fetched |

## Verification
The tests use each burst class: 1, 8, 16 and 24/32-bit depths, plus one depth value that is not supported. The window widths are picked so that some lines split into a full burst plus a short tail, and others divide exactly into bursts. Together these separate errors in the burst choice from errors in the tail-length logic. A non-zero origin and a non-zero skip separate mistakes in the origin calculation from mistakes in the line-to-line stride. A run with intermittent `req_ready` checks that a stalled request is held. A mid-frame restart and an empty window check the frame-start and termination paths.

// File: rtl/win_fetch_pkg.sv
package win_fetch_pkg;
  localparam int WORD_BYTES = 4;
  localparam int LEN_W      = 5;

  // effective stored bits per pixel; unknown depths become unpacked 24-bit (32)
  function automatic logic [5:0] eff_bits(input logic [5:0] dep);
    case (dep)
      6'd1, 6'd2, 6'd4, 6'd8, 6'd16, 6'd24, 6'd32: eff_bits = dep;
      default:                                     eff_bits = 6'd32;
    endcase
  endfunction

  function automatic logic [LEN_W-1:0] burst_len(input logic [5:0] dep);
    case (dep)
      6'd1:              burst_len = LEN_W'(4);
      6'd2, 6'd4, 6'd8:  burst_len = LEN_W'(8);
      default:           burst_len = LEN_W'(16);
    endcase
  endfunction
endpackage

// File: rtl/win_fetch_geom.sv
module win_fetch_geom
  import win_fetch_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 12,
  parameter int PW = 16,
  localparam int PRW = DW + 6,
  localparam int LWW = PRW - 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [AW-1:0]    base_addr,
  input  logic [DW-1:0]    org_x,
  input  logic [DW-1:0]    org_y,
  input  logic [PW-1:0]    pitch,
  input  logic [DW-1:0]    fb_width,
  input  logic [DW-1:0]    win_width,
  input  logic [DW-1:0]    win_height,
  input  logic [5:0]       depth,
  output logic [AW-1:0]    start_c,
  output logic [LWW-1:0]   line_words_c,
  output logic             empty_c,
  output logic [LWW-1:0]   line_words_q,
  output logic [AW-1:0]    skip_q,
  output logic [AW-1:0]    end_q,
  output logic [LEN_W-1:0] burst_q
);
  logic [5:0]     eb;
  logic [PRW-1:0] win_bits, fb_bits, skip_bits, x_bits;
  logic [AW-1:0]  origin, fb_line_bytes, end_c, skip_c;

  always_comb begin
    eb            = eff_bits(depth);
    win_bits      = PRW'(win_width) * PRW'(eb);
    fb_bits       = PRW'(fb_width) * PRW'(eb);
    skip_bits     = PRW'(fb_width - win_width) * PRW'(eb);
    x_bits        = PRW'(org_x) * PRW'(eb);
    origin        = AW'(x_bits >> 3) + AW'(org_y) * AW'(pitch);
    start_c       = base_addr + origin;
    line_words_c  = LWW'(win_bits >> 5);
    skip_c        = AW'(skip_bits >> 3);
    fb_line_bytes = AW'(fb_bits >> 3);
    end_c         = start_c + fb_line_bytes * AW'(win_height);
    empty_c       = (line_words_c == '0) || (win_height == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_words_q <= '0;
      skip_q       <= '0;
      end_q        <= '0;
      burst_q      <= '0;
    end else if (load) begin
      line_words_q <= line_words_c;
      skip_q       <= skip_c;
      end_q        <= end_c;
      burst_q      <= burst_len(depth);
    end
  end
endmodule

// File: rtl/win_fetch_walker.sv
module win_fetch_walker
  import win_fetch_pkg::*;
#(
  parameter int AW  = 32,
  parameter int LWW = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [AW-1:0]    start_c,
  input  logic [LWW-1:0]   line_words_c,
  input  logic             empty_c,
  input  logic [LWW-1:0]   line_words_q,
  input  logic [AW-1:0]    skip_q,
  input  logic [AW-1:0]    end_q,
  input  logic [LEN_W-1:0] burst_q,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [AW-1:0]    req_addr,
  output logic [LEN_W-1:0] req_words,
  output logic             done
);
  logic [AW-1:0]  cur;
  logic [LWW-1:0] left, burst_ext, chunk;
  logic [AW-1:0]  step, nxt_line;
  logic           active, fire;

  always_comb begin
    burst_ext = LWW'(burst_q);
    chunk     = (left < burst_ext) ? left : burst_ext;
    step      = AW'(chunk) << 2;
    nxt_line  = cur + step + skip_q;
    fire      = active && req_ready;
  end

  assign req_valid = active;
  assign req_addr  = cur;
  assign req_words = LEN_W'(chunk);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur    <= '0;
      left   <= '0;
      active <= 1'b0;
      done   <= 1'b0;
    end else if (load) begin
      cur    <= start_c;
      left   <= line_words_c;
      active <= !empty_c;
      done   <= empty_c;
    end else if (fire) begin
      if (left > chunk) begin
        cur  <= cur + step;
        left <= left - chunk;
      end else if (nxt_line >= end_q) begin
        active <= 1'b0;
        done   <= 1'b1;
      end else begin
        cur  <= nxt_line;
        left <= line_words_q;
      end
    end
  end

  assert_len_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_words != '0) && (req_words <= burst_q));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !load) |=>
      (req_valid && $stable(req_addr) && $stable(req_words)));

  assert_end_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_addr + (AW'(req_words) << 2) <= end_q));

  assert_done_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_valid);

  assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !empty_c) |=> (req_valid && !done && req_addr == $past(start_c)));
endmodule

// File: rtl/win_line_fetch.sv
module win_line_fetch
  import win_fetch_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 12,
  parameter int PW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic [AW-1:0]    base_addr,
  input  logic [DW-1:0]    org_x,
  input  logic [DW-1:0]    org_y,
  input  logic [PW-1:0]    pitch,
  input  logic [DW-1:0]    fb_width,
  input  logic [DW-1:0]    win_width,
  input  logic [DW-1:0]    win_height,
  input  logic [5:0]       depth,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [AW-1:0]    req_addr,
  output logic [LEN_W-1:0] req_words,
  output logic             done
);
  localparam int LWW = DW + 1;

  logic [AW-1:0]    start_c, skip_q, end_q;
  logic [LWW-1:0]   line_words_c, line_words_q;
  logic             empty_c;
  logic [LEN_W-1:0] burst_q;

  win_fetch_geom #(.AW(AW), .DW(DW), .PW(PW)) u_geom (
    .clk(clk), .rst_n(rst_n), .load(frame_start),
    .base_addr(base_addr), .org_x(org_x), .org_y(org_y), .pitch(pitch),
    .fb_width(fb_width), .win_width(win_width), .win_height(win_height),
    .depth(depth), .start_c(start_c), .line_words_c(line_words_c),
    .empty_c(empty_c), .line_words_q(line_words_q), .skip_q(skip_q),
    .end_q(end_q), .burst_q(burst_q)
  );

  win_fetch_walker #(.AW(AW), .LWW(LWW)) u_walk (
    .clk(clk), .rst_n(rst_n), .load(frame_start),
    .start_c(start_c), .line_words_c(line_words_c), .empty_c(empty_c),
    .line_words_q(line_words_q), .skip_q(skip_q), .end_q(end_q),
    .burst_q(burst_q), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_words(req_words), .done(done)
  );

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> $past(frame_start));
endmodule

// File: tb/win_line_fetch_tb.sv
module win_line_fetch_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_start = 1'b0;
  logic [31:0] base_addr = '0;
  logic [11:0] org_x = '0, org_y = '0, fb_width = '0, win_width = '0, win_height = '0;
  logic [15:0] pitch = '0;
  logic [5:0]  depth = '0;
  logic        req_ready = 1'b0;
  logic        req_valid, done;
  logic [31:0] req_addr;
  logic [4:0]  req_words;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int exp_n;
  logic [31:0] exp_addr [0:511];
  int          exp_len  [0:511];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  win_line_fetch u_dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .base_addr(base_addr),
    .org_x(org_x), .org_y(org_y), .pitch(pitch), .fb_width(fb_width),
    .win_width(win_width), .win_height(win_height), .depth(depth),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_words(req_words), .done(done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // expected request list from the stated geometry rules
  task automatic build_expect();
    int bits, bw, lineb, skip, start, a, left, l;
    case (depth)
      1, 2, 4, 8, 16, 24, 32: bits = depth;
      default: bits = 32;
    endcase
    bw = (depth == 1) ? 4 : (depth == 2 || depth == 4 || depth == 8) ? 8 : 16;
    lineb = win_width * bits / 8;
    skip  = (fb_width - win_width) * bits / 8;
    start = base_addr + org_x * bits / 8 + org_y * pitch;
    exp_n = 0;
    if (lineb / 4 == 0) return;
    for (int r = 0; r < win_height; r++) begin
      a = start + r * (lineb + skip);
      left = lineb / 4;
      while (left > 0) begin
        l = (left < bw) ? left : bw;
        exp_addr[exp_n] = a; exp_len[exp_n] = l; exp_n++;
        a += l * 4; left -= l;
      end
    end
  endtask

  task automatic pulse();
    @(negedge clk);
    req_ready = 1'b0;
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  // mode 0: always ready; mode 1: ready two cycles in three
  task automatic run_frame(input string tag, input int mode, input int stop_after);
    int idx = 0;
    logic [31:0] held_a;
    logic held = 1'b0;
    build_expect();
    pulse();
    if (exp_n == 0) begin
      check({tag, " R10 done"}, done, 1);
      check({tag, " R10 no req"}, req_valid, 0);
      return;
    end
    check({tag, " R9 done cleared"}, done, 0);
    check({tag, " R2 first addr"}, req_addr, exp_addr[0]);
    while (idx < exp_n && idx < stop_after) begin
      req_ready = (mode == 0) ? 1'b1 : (cyc % 3 != 0);
      if (held) begin
        check({tag, " R8 held addr"}, req_addr, held_a);
        held = 1'b0;
      end
      if (req_valid && req_ready) begin
        check({tag, " R5 R6 addr"}, req_addr, exp_addr[idx]);
        check({tag, " R3 R5 len"}, {27'd0, req_words}, exp_len[idx]);
        idx++;
      end else if (req_valid) begin
        held = 1'b1; held_a = req_addr;
      end else begin
        check({tag, " valid during walk"}, req_valid, 1);
      end
      @(negedge clk);
    end
    req_ready = 1'b0;
    if (stop_after >= exp_n) begin
      check({tag, " R7 done"}, done, 1);
      check({tag, " R7 quiet"}, req_valid, 0);
      repeat (3) @(negedge clk);
      check({tag, " R7 done sticky"}, done, 1);
    end
  endtask

  task automatic cfg(input logic [31:0] b, input int x, input int y, input int p,
                     input int fw, input int ww, input int h, input int d);
    base_addr = b; org_x = x; org_y = y; pitch = p;
    fb_width = fw; win_width = ww; win_height = h; depth = d;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R1 valid idle", req_valid, 0);
    check("R1 done idle", done, 0);
  endtask

  task automatic t_depth32(); cfg(32'h1000, 2, 1, 160, 40, 20, 3, 32); run_frame("d32", 0, 999); endtask
  task automatic t_depth8();  cfg(32'h4000, 4, 2, 64, 64, 36, 2, 8);  run_frame("d8", 0, 999); endtask
  task automatic t_depth1();  cfg(32'h8000, 32, 1, 64, 512, 256, 2, 1); run_frame("d1", 0, 999); endtask
  task automatic t_depth24(); cfg(32'h2000, 4, 2, 48, 16, 8, 2, 24); run_frame("d24", 0, 999); endtask
  task automatic t_stall16(); cfg(32'h10000, 2, 3, 128, 64, 40, 3, 16); run_frame("d16 stall", 1, 999); endtask
  task automatic t_bad_depth(); cfg(32'h3000, 1, 0, 200, 50, 20, 2, 12); run_frame("R4 depth12", 0, 999); endtask
  task automatic t_restart();
    cfg(32'h5000, 0, 1, 160, 40, 40, 4, 32);
    run_frame("restart part", 0, 2);
    run_frame("R9 restart", 1, 999);
  endtask
  task automatic t_empty();
    cfg(32'h6000, 0, 0, 64, 16, 16, 0, 32); run_frame("R10 h0", 0, 999);
    cfg(32'h6000, 0, 0, 64, 16, 2, 3, 8);   run_frame("R10 narrow", 0, 999);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_depth32();
    t_depth8();
    t_depth1();
    t_depth24();
    t_stall16();
    t_bad_depth();
    t_restart();
    t_empty();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule